// File: doc/BRIEF.md
# Shift and Rotate Execution Unit with Memory Read-Modify-Write

This unit executes the four single-bit shift and rotate operations of a small accumulator processor on an 8-bit operand. The operations are shift left, shift right, rotate left through carry and rotate right through carry. The operand comes from one of two places. If it is the accumulator, the unit returns the new accumulator and flags in a two-cycle operation. If it is a byte in memory, the unit reads the byte through a synchronous memory port, computes the new value, writes it back to the same address, and returns flags while the accumulator passes through unchanged.

One combinational shifter serves both paths. A sequencer supplies that shifter with either the live accumulator or the byte it fetched. For memory forms, the sequencer pads the operation with wait states so that the total cycle count matches the instruction's addressing class. Each operation ends with a single-cycle `done` pulse. Address decoding and instruction fetch happen outside the unit. The caller only supplies the effective address and the addressing class.

Top module: `shift_rmw_unit`

## Requirements
- R1: Operation code 0 (shift left): the result is the operand moved up one bit with 0 in bit 0, and the carry output takes the operand's bit 7.
- R2: Operation code 1 (shift right): the result is the operand moved down one bit with 0 in bit 7, and the carry output takes the operand's bit 0.
- R3: Operation code 2 (rotate left): the result is the operand moved up one bit with the incoming carry in bit 0, and the carry output takes the operand's bit 7.
- R4: Operation code 3 (rotate right): the result is the operand moved down one bit with the incoming carry in bit 7, and the carry output takes the operand's bit 0.
- R5: At every `done`, `zero_out` is 1 exactly when the 8-bit result is 0, and `neg_out` equals bit 7 of the result.
- R6: With `src_mem`=0, a start accepted in cycle 1 raises `done` in cycle 2 with `acc_out` holding the result, and `mem_we` stays low.
- R7: With `src_mem`=1, the unit reads the byte at `addr_in`, writes the result back to that same address, and `acc_out` equals the `acc_in` sampled at start.
- R8: A memory form takes 5, 6, 6 or 7 cycles for `mem_kind` 0, 1, 2 or 3, counting the start cycle as cycle 1, and `done` is high only in the last of these cycles.
- R9: In a memory form, `mem_we` is high for exactly one cycle, and that cycle is the `done` cycle.
- R10: While a memory form is in progress, `start` is ignored: it causes no extra `done`, changes neither `acc_out` nor the target byte, and leaves `mem_addr` unchanged.
- R11: After synchronous reset, `done`, `mem_we`, `acc_out`, `carry_out`, `zero_out` and `neg_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (ignored while busy) |
| op | input | 2 | 0 shift left, 1 shift right, 2 rotate left, 3 rotate right |
| src_mem | input | 1 | 0 accumulator operand, 1 memory operand |
| mem_kind | input | 2 | Memory addressing class that selects the cycle count |
| acc_in | input | 8 | Current accumulator |
| carry_in | input | 1 | Current carry flag |
| addr_in | input | 16 | Effective address of the memory operand |
| mem_addr | output | 16 | Memory port address |
| mem_rdata | input | 8 | Memory read data, valid one cycle after the address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| acc_out | output | 8 | New accumulator |
| carry_out | output | 1 | New carry flag |
| zero_out | output | 1 | New zero flag |
| neg_out | output | 1 | New negative flag |
| done | output | 1 | Single-cycle completion pulse |

## Verification
The assertions check several properties on every cycle. Shift-left results have a clear bit 0 and shift-right results have a clear bit 7. A rotate preserves the total count of set bits across operand and carry. The flags agree with whichever result is presented at `done`. The write strobe is a one-cycle pulse inside `done`. An accumulator start completes on the next cycle without a write. The memory address holds steady while busy. The bench scenarios cover what the assertions leave open. They check the exact result and carry values across every operand, carry and operation. They check the cycle count for each addressing class and the byte left in memory. They confirm that the accumulator passes through memory forms unchanged. They also confirm that starts issued mid-operation leave no trace.

// File: rtl/srw_pkg.sv
package srw_pkg;
  typedef enum logic [1:0] {
    SH_LEFT  = 2'd0,
    SH_RIGHT = 2'd1,
    RT_LEFT  = 2'd2,
    RT_RIGHT = 2'd3
  } srw_op_e;

  typedef enum logic [1:0] {
    KIND_SHORT     = 2'd0,
    KIND_SHORT_IDX = 2'd1,
    KIND_LONG      = 2'd2,
    KIND_LONG_IDX  = 2'd3
  } srw_kind_e;
endpackage

// File: rtl/srw_core.sv
module srw_core
  import srw_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  srw_op_e       op,
  input  logic [DW-1:0] opnd,
  input  logic          cin,
  output logic [DW-1:0] res,
  output logic          cout
);
  // Carry is taken from the original operand bit; the result is formed separately.
  always_comb begin
    unique case (op)
      SH_LEFT: begin
        cout = opnd[DW-1];
        res  = {opnd[DW-2:0], 1'b0};
      end
      SH_RIGHT: begin
        cout = opnd[0];
        res  = {1'b0, opnd[DW-1:1]};
      end
      RT_LEFT: begin
        cout = opnd[DW-1];
        res  = {opnd[DW-2:0], cin};
      end
      default: begin
        cout = opnd[0];
        res  = {cin, opnd[DW-1:1]};
      end
    endcase
  end

  assert_left_fill_R1: assert property (@(posedge clk) disable iff (rst)
    (op == SH_LEFT) |-> (res[0] == 1'b0));

  assert_right_fill_R2: assert property (@(posedge clk) disable iff (rst)
    (op == SH_RIGHT) |-> (res[DW-1] == 1'b0));

  assert_rot_left_bits_R3: assert property (@(posedge clk) disable iff (rst)
    (op == RT_LEFT) |-> ($countones({res, cout}) == $countones({opnd, cin})));

  assert_rot_right_bits_R4: assert property (@(posedge clk) disable iff (rst)
    (op == RT_RIGHT) |-> ($countones({res, cout}) == $countones({opnd, cin})));
endmodule

// File: rtl/srw_seq.sv
module srw_seq
  import srw_pkg::*;
#(
  parameter int DW       = 8,
  parameter int AW       = 16,
  parameter int CYC_S    = 5,
  parameter int CYC_SI   = 6,
  parameter int CYC_L    = 6,
  parameter int CYC_LI   = 7,
  parameter int RD_SLOT  = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  srw_op_e       op,
  input  logic          src_mem,
  input  srw_kind_e     kind,
  input  logic [DW-1:0] acc_in,
  input  logic          carry_in,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] mem_rdata,
  // shifter interface
  output srw_op_e       c_op,
  output logic [DW-1:0] c_opnd,
  output logic          c_cin,
  input  logic [DW-1:0] c_res,
  input  logic          c_cout,
  // results
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic [DW-1:0] acc_out,
  output logic          carry_out,
  output logic          zero_out,
  output logic          neg_out,
  output logic          done
);
  localparam int CMAX = (CYC_S > CYC_SI ? CYC_S : CYC_SI) > (CYC_L > CYC_LI ? CYC_L : CYC_LI)
                      ? (CYC_S > CYC_SI ? CYC_S : CYC_SI) : (CYC_L > CYC_LI ? CYC_L : CYC_LI);
  localparam int CW   = $clog2(CMAX + 1);

  logic          busy;
  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;
  srw_op_e       op_q;
  logic          cin_q;
  logic [DW-1:0] acc_q;
  logic [DW-1:0] byte_q;

  // Edge index (counted from the start edge) at which the write and done are issued.
  function automatic logic [CW-1:0] last_edge(srw_kind_e k);
    unique case (k)
      KIND_SHORT:     last_edge = CW'(CYC_S - 2);
      KIND_SHORT_IDX: last_edge = CW'(CYC_SI - 2);
      KIND_LONG:      last_edge = CW'(CYC_L - 2);
      default:        last_edge = CW'(CYC_LI - 2);
    endcase
  endfunction

  // Operand select: live accumulator when idle, fetched byte while busy.
  always_comb begin
    if (busy) begin
      c_op   = op_q;
      c_opnd = byte_q;
      c_cin  = cin_q;
    end else begin
      c_op   = op;
      c_opnd = acc_in;
      c_cin  = carry_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      cnt       <= '0;
      lim       <= '0;
      op_q      <= SH_LEFT;
      cin_q     <= 1'b0;
      acc_q     <= '0;
      byte_q    <= '0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_we    <= 1'b0;
      acc_out   <= '0;
      carry_out <= 1'b0;
      zero_out  <= 1'b0;
      neg_out   <= 1'b0;
      done      <= 1'b0;
    end else begin
      done   <= 1'b0;
      mem_we <= 1'b0;
      if (!busy) begin
        if (start) begin
          if (!src_mem) begin
            acc_out   <= c_res;
            carry_out <= c_cout;
            zero_out  <= (c_res == '0);
            neg_out   <= c_res[DW-1];
            done      <= 1'b1;
          end else begin
            busy     <= 1'b1;
            cnt      <= CW'(1);
            lim      <= last_edge(kind);
            mem_addr <= addr_in;
            op_q     <= op;
            cin_q    <= carry_in;
            acc_q    <= acc_in;
          end
        end
      end else begin
        cnt <= cnt + 1'b1;
        if (cnt == CW'(RD_SLOT)) begin
          byte_q <= mem_rdata;
        end
        if (cnt == lim) begin
          busy      <= 1'b0;
          mem_we    <= 1'b1;
          mem_wdata <= c_res;
          acc_out   <= acc_q;
          carry_out <= c_cout;
          zero_out  <= (c_res == '0);
          neg_out   <= c_res[DW-1];
          done      <= 1'b1;
        end
      end
    end
  end

  assert_acc_done_R6: assert property (@(posedge clk) disable iff (rst)
    (start && !src_mem && !busy) |=> (done && !mem_we));

  assert_we_single_R9: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  assert_we_in_done_R9: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> done);

  assert_zero_flag_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> (zero_out == ((mem_we ? mem_wdata : acc_out) == '0)));

  assert_neg_flag_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> (neg_out == (mem_we ? mem_wdata[DW-1] : acc_out[DW-1])));

  assert_addr_hold_R10: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(mem_addr));
endmodule

// File: rtl/shift_rmw_unit.sv
module shift_rmw_unit
  import srw_pkg::*;
#(
  parameter int DW     = 8,
  parameter int AW     = 16,
  parameter int CYC_S  = 5,
  parameter int CYC_SI = 6,
  parameter int CYC_L  = 6,
  parameter int CYC_LI = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [1:0]    op,
  input  logic          src_mem,
  input  logic [1:0]    mem_kind,
  input  logic [DW-1:0] acc_in,
  input  logic          carry_in,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic [DW-1:0] acc_out,
  output logic          carry_out,
  output logic          zero_out,
  output logic          neg_out,
  output logic          done
);
  srw_op_e       c_op;
  logic [DW-1:0] c_opnd;
  logic          c_cin;
  logic [DW-1:0] c_res;
  logic          c_cout;

  srw_seq #(
    .DW(DW), .AW(AW), .CYC_S(CYC_S), .CYC_SI(CYC_SI), .CYC_L(CYC_L), .CYC_LI(CYC_LI),
    .RD_SLOT(2)
  ) u_seq (
    .clk(clk), .rst(rst), .start(start), .op(srw_op_e'(op)), .src_mem(src_mem),
    .kind(srw_kind_e'(mem_kind)), .acc_in(acc_in), .carry_in(carry_in),
    .addr_in(addr_in), .mem_rdata(mem_rdata),
    .c_op(c_op), .c_opnd(c_opnd), .c_cin(c_cin), .c_res(c_res), .c_cout(c_cout),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .acc_out(acc_out), .carry_out(carry_out), .zero_out(zero_out),
    .neg_out(neg_out), .done(done)
  );

  srw_core #(.DW(DW)) u_core (
    .clk(clk), .rst(rst), .op(c_op), .opnd(c_opnd), .cin(c_cin),
    .res(c_res), .cout(c_cout)
  );
endmodule

// File: tb/sim_shift_rmw_unit.sv
module sim_shift_rmw_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  op = 2'd0;
  logic        src_mem = 1'b0;
  logic [1:0]  mem_kind = 2'd0;
  logic [7:0]  acc_in = 8'd0;
  logic        carry_in = 1'b0;
  logic [15:0] addr_in = 16'd0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic [7:0]  mem_wdata;
  logic        mem_we;
  logic [7:0]  acc_out;
  logic        carry_out, zero_out, neg_out, done;

  logic        tb_we = 1'b0;
  logic [7:0]  tb_addr = 8'd0;
  logic [7:0]  tb_data = 8'd0;
  logic [7:0]  ram [256];

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shift_rmw_unit u0 (
    .clk(clk), .rst(rst), .start(start), .op(op), .src_mem(src_mem),
    .mem_kind(mem_kind), .acc_in(acc_in), .carry_in(carry_in), .addr_in(addr_in),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .acc_out(acc_out), .carry_out(carry_out), .zero_out(zero_out), .neg_out(neg_out),
    .done(done)
  );

  always_ff @(posedge clk) begin
    if (mem_we) ram[mem_addr[7:0]] <= mem_wdata;
    else if (tb_we) ram[tb_addr] <= tb_data;
    mem_rdata <= ram[mem_addr[7:0]];
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_res(int o, int v, int c);
    case (o)
      0: return (v * 2) % 256;
      1: return v / 2;
      2: return (v * 2) % 256 + c;
      default: return v / 2 + c * 128;
    endcase
  endfunction

  function automatic int exp_cy(int o, int v);
    if (o == 0 || o == 2) return (v >= 128) ? 1 : 0;
    return v % 2;
  endfunction

  function automatic string op_tag(int o);
    case (o)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      default: return "R4";
    endcase
  endfunction

  function automatic int kind_cycles(int k);
    case (k)
      0: return 5;
      1: return 6;
      2: return 6;
      default: return 7;
    endcase
  endfunction

  task automatic acc_op(int o, int v, int c);
    int r;
    r = exp_res(o, v, c);
    @(negedge clk);
    start = 1'b1; op = 2'(o); src_mem = 1'b0; acc_in = 8'(v); carry_in = 1'(c);
    @(negedge clk);
    start = 1'b0;
    chk("R6 done", int'(done), 1);
    chk("R6 we", int'(mem_we), 0);
    chk(op_tag(o), int'(acc_out), r);
    chk(op_tag(o), int'(carry_out), exp_cy(o, v));
    chk("R5 flags", int'({zero_out, neg_out}), ((r == 0) ? 2 : 0) + ((r >= 128) ? 1 : 0));
  endtask

  task automatic mem_op(int o, int v, int c, int k, int a, int acc, bit inject);
    int r, n, done_at, done_cnt, we_cnt, we_ok;
    r = exp_res(o, v, c);
    n = kind_cycles(k);
    @(negedge clk);
    tb_we = 1'b1; tb_addr = 8'(a); tb_data = 8'(v);
    @(negedge clk);
    tb_we = 1'b0;
    start = 1'b1; op = 2'(o); src_mem = 1'b1; mem_kind = 2'(k);
    acc_in = 8'(acc); carry_in = 1'(c); addr_in = 16'(a);
    done_at = 0; done_cnt = 0; we_cnt = 0; we_ok = 1;
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk);
      if (done) begin done_at = i; done_cnt++; end
      if (mem_we) begin
        we_cnt++;
        if (!done) we_ok = 0;
      end
      if (inject && i >= 1 && i <= 2) begin
        start = 1'b1; src_mem = 1'b0; acc_in = 8'(~acc); addr_in = 16'(a ^ 1);
        op = 2'(o ^ 1);
      end else begin
        start = 1'b0;
      end
    end
    chk("R8 done cycle", done_at, n - 1);
    chk("R8 done count", done_cnt, 1);
    chk("R9 we count", we_cnt, 1);
    chk("R9 we in done", we_ok, 1);
    chk(op_tag(o), int'(ram[8'(a)]), r);
    chk(op_tag(o), int'(carry_out), exp_cy(o, v));
    chk("R5 flags", int'({zero_out, neg_out}), ((r == 0) ? 2 : 0) + ((r >= 128) ? 1 : 0));
    chk("R7 acc", int'(acc_out), acc);
    if (inject) chk("R10 ignored start", int'(acc_out), acc);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 done", int'(done), 0);
    chk("R11 we", int'(mem_we), 0);
    chk("R11 acc", int'(acc_out), 0);
    chk("R11 flags", int'({carry_out, zero_out, neg_out}), 0);

    for (int o = 0; o < 4; o++)
      for (int v = 0; v < 256; v++)
        for (int c = 0; c < 2; c++)
          acc_op(o, v, c);

    for (int v = 0; v < 256; v++)
      for (int o = 0; o < 4; o++)
        for (int c = 0; c < 2; c++)
          mem_op(o, v, c, (v + o + c) % 4, (v * 7 + o) % 256, (v ^ 8'h5a) % 256,
                 (v % 16) == 3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule